// File: doc/BRIEF.md
# Victim Line Buffer with Dirty Drain

The block is a small, fully associative store that holds lines recently evicted from a set-associative first-level cache. Every eviction is offered to it. Any entry can hold a line from any set, so the buffer acts as one extra way that all sets share. When the cache misses, the full line address is compared against every entry in the same cycle. A hit returns the line and its modified flag, and the entry is released so that the line can move back into the cache.

The buffer also serves as the writeback buffer for modified lines. The oldest modified entry is offered to the next level over a valid/ready pair. When the next level accepts it, the entry stays in the buffer as a clean copy. Clean lines never need to be written back.

When all entries are occupied, a new eviction overwrites the clean entry that has been resident longest. If every entry is still modified, the eviction is held off until a drain completes. Each entry carries a valid bit, a modified bit, a 58-bit line address and a 64-byte line.

Top module: `victim_wb_buffer`

## Requirements
- R1: After reset the buffer is empty: `ins_ready` is 1, `wb_valid` is 0, and every lookup misses.
- R2: With `lk_valid` high, `lk_hit` rises in the same cycle if a valid entry holds `lk_addr`, and `lk_data`/`lk_dirty` carry that entry's line and modified flag. `lk_hit` is 0 whenever `lk_valid` is 0 or no entry matches.
- R3: A lookup hit frees the entry at the next clock edge. A later lookup of the same address misses, and the line is never offered for drain again.
- R4: While fewer than ENTRIES entries are valid, an insert (`ins_valid` with `ins_ready`) always lands in a free entry and evicts nothing. ENTRIES distinct lines can be held at once.
- R5: With all entries valid, an insert replaces the clean entry that was inserted earliest. All other entries survive.
- R6: `ins_ready` is 0 exactly when all entries are valid and modified. It depends only on stored state. An insert offered while it is 0 has no effect.
- R7: `wb_valid` is 1 whenever at least one valid entry is modified. `wb_addr`/`wb_data` then show the modified entry that was inserted earliest.
- R8: When `wb_valid` and `wb_ready` are both high at a clock edge, that entry's modified flag clears but the entry stays valid. A later lookup returns it with `lk_dirty` 0, and the next-oldest modified entry is offered in the next cycle.
- R9: While `wb_valid` is high and `wb_ready` is low, the offered line stays the same in the next cycle. The only exception is a lookup that hits that line.
- R10: Operations in the same cycle all take effect. If a lookup hits the entry that an insert replaces, the lookup returns the old line and the new line is kept. A lookup that hits the line being drained in that cycle returns `lk_dirty` 1 and removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Evicted line offered for insertion |
| ins_ready | output | 1 | Insertion can be accepted this cycle |
| ins_addr | input | 58 | Line address of the evicted line |
| ins_dirty | input | 1 | Evicted line is modified |
| ins_data | input | 512 | Evicted line contents |
| lk_valid | input | 1 | Lookup request on a cache miss |
| lk_addr | input | 58 | Line address searched |
| lk_hit | output | 1 | Lookup found the line |
| lk_dirty | output | 1 | Modified flag of the found line |
| lk_data | output | 512 | Contents of the found line |
| wb_valid | output | 1 | A modified line is offered to the next level |
| wb_ready | input | 1 | Next level accepts the offered line |
| wb_addr | output | 58 | Line address of the offered line |
| wb_data | output | 512 | Contents of the offered line |

## Verification
Several properties are checked on every cycle by the assertions:
- the empty state right after reset;
- at most one matching entry per lookup;
- no hit without a request;
- release of a hit entry;
- a stall only while a drain is pending;
- a held drain offer while the next level is busy;
- an accepted line not being offered again.

Some behaviours depend on insertion history, so only the bench's cycle-by-cycle queue model can show them:
- which clean line a full buffer gives up;
- which modified line goes out first;
- the contents returned on hits;
- the outcome of lookups, inserts and drains that collide in one cycle.

// File: rtl/vcb_pkg.sv
`timescale 1ns/1ps
package vcb_pkg;
    localparam int LINE_ADDR_W = 58;
    localparam int LINE_BYTES  = 64;
    localparam int LINE_W      = LINE_BYTES * 8;

    typedef logic [LINE_ADDR_W-1:0] line_addr_t;
    typedef logic [LINE_W-1:0]      line_data_t;

    typedef struct packed {
        logic       valid;
        logic       dirty;
        line_addr_t addr;
        line_data_t data;
    } vcb_entry_t;

    function automatic logic line_match(input vcb_entry_t e, input line_addr_t a);
        return e.valid && (e.addr == a);
    endfunction
endpackage

// File: rtl/vcb_lookup.sv
`timescale 1ns/1ps
module vcb_lookup
    import vcb_pkg::*;
#(
    parameter int N = 4
) (
    input  vcb_entry_t [N-1:0] ents,
    input  logic               lk_valid,
    input  line_addr_t         lk_addr,
    output logic [N-1:0]       hit_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = lk_valid && line_match(ents[g], lk_addr);
    end
endmodule

// File: rtl/vcb_age.sv
`timescale 1ns/1ps
module vcb_age #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         alloc_en,
    input  logic [N-1:0] alloc_oh,
    input  logic [N-1:0] cand_clean,
    input  logic [N-1:0] cand_dirty,
    output logic [N-1:0] oldest_clean,
    output logic [N-1:0] oldest_dirty
);
    // before_q[j][i] is set when entry j was filled earlier than entry i
    logic [N-1:0] before_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < N; j++) before_q[j] <= '0;
        end else if (alloc_en) begin
            for (int j = 0; j < N; j++) begin
                for (int i = 0; i < N; i++) begin
                    if (alloc_oh[j])      before_q[j][i] <= 1'b0;
                    else if (alloc_oh[i]) before_q[j][i] <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_pick
        logic [N-1:0] col;
        always_comb begin
            for (int j = 0; j < N; j++) col[j] = before_q[j][g];
        end
        assign oldest_clean[g] = cand_clean[g] && !(|(cand_clean & col));
        assign oldest_dirty[g] = cand_dirty[g] && !(|(cand_dirty & col));
    end
endmodule

// File: rtl/vcb_slot_pick.sv
`timescale 1ns/1ps
module vcb_slot_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] valid_vec,
    input  logic [N-1:0] oldest_clean,
    output logic [N-1:0] alloc_oh,
    output logic         can_alloc
);
    logic [N-1:0] free_oh;
    logic         have_free;

    always_comb begin
        free_oh   = '0;
        have_free = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!valid_vec[i] && !have_free) begin
                free_oh[i] = 1'b1;
                have_free  = 1'b1;
            end
        end
    end

    assign alloc_oh  = have_free ? free_oh : oldest_clean;
    assign can_alloc = have_free || (|oldest_clean);
endmodule

// File: rtl/vcb_store.sv
`timescale 1ns/1ps
module vcb_store
    import vcb_pkg::*;
#(
    parameter int N = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ins_fire,
    input  logic [N-1:0]       alloc_oh,
    input  vcb_entry_t         new_ent,
    input  logic [N-1:0]       kill_oh,
    input  logic [N-1:0]       clean_oh,
    output vcb_entry_t [N-1:0] ents
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        vcb_entry_t ent_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q.valid <= 1'b0;
                ent_q.dirty <= 1'b0;
            end else if (ins_fire && alloc_oh[g]) begin
                ent_q <= new_ent;
            end else begin
                if (kill_oh[g])  ent_q.valid <= 1'b0;
                if (clean_oh[g]) ent_q.dirty <= 1'b0;
            end
        end
        assign ents[g] = ent_q;
    end
endmodule

// File: rtl/victim_wb_buffer.sv
`timescale 1ns/1ps
module victim_wb_buffer
    import vcb_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ins_valid,
    output logic                   ins_ready,
    input  logic [LINE_ADDR_W-1:0] ins_addr,
    input  logic                   ins_dirty,
    input  logic [LINE_W-1:0]      ins_data,
    input  logic                   lk_valid,
    input  logic [LINE_ADDR_W-1:0] lk_addr,
    output logic                   lk_hit,
    output logic                   lk_dirty,
    output logic [LINE_W-1:0]      lk_data,
    output logic                   wb_valid,
    input  logic                   wb_ready,
    output logic [LINE_ADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0]      wb_data
);
    localparam int N = ENTRIES;

    vcb_entry_t [N-1:0] ents;
    vcb_entry_t         new_ent;
    logic [N-1:0]       hit_vec;
    logic [N-1:0]       valid_vec;
    logic [N-1:0]       clean_vec;
    logic [N-1:0]       dirty_vec;
    logic [N-1:0]       oldest_clean;
    logic [N-1:0]       oldest_dirty;
    logic [N-1:0]       alloc_oh;
    logic [N-1:0]       clean_oh;
    logic               can_alloc;
    logic               ins_fire;

    for (genvar g = 0; g < N; g++) begin : g_state
        assign valid_vec[g] = ents[g].valid;
        assign clean_vec[g] = ents[g].valid && !ents[g].dirty;
        assign dirty_vec[g] = ents[g].valid &&  ents[g].dirty;
    end

    assign new_ent = '{valid: 1'b1, dirty: ins_dirty, addr: ins_addr, data: ins_data};

    vcb_lookup #(.N(N)) i_lookup (
        .ents     (ents),
        .lk_valid (lk_valid),
        .lk_addr  (lk_addr),
        .hit_vec  (hit_vec)
    );

    vcb_age #(.N(N)) i_age (
        .clk          (clk),
        .rst          (rst),
        .alloc_en     (ins_fire),
        .alloc_oh     (alloc_oh),
        .cand_clean   (clean_vec),
        .cand_dirty   (dirty_vec),
        .oldest_clean (oldest_clean),
        .oldest_dirty (oldest_dirty)
    );

    vcb_slot_pick #(.N(N)) i_pick (
        .valid_vec    (valid_vec),
        .oldest_clean (oldest_clean),
        .alloc_oh     (alloc_oh),
        .can_alloc    (can_alloc)
    );

    assign ins_ready = can_alloc;
    assign ins_fire  = ins_valid && can_alloc;
    assign clean_oh  = oldest_dirty & {N{wb_ready}};

    vcb_store #(.N(N)) i_store (
        .clk      (clk),
        .rst      (rst),
        .ins_fire (ins_fire),
        .alloc_oh (alloc_oh),
        .new_ent  (new_ent),
        .kill_oh  (hit_vec),
        .clean_oh (clean_oh),
        .ents     (ents)
    );

    always_comb begin
        lk_hit   = |hit_vec;
        lk_dirty = 1'b0;
        lk_data  = '0;
        wb_valid = |oldest_dirty;
        wb_addr  = '0;
        wb_data  = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                lk_dirty = lk_dirty | ents[i].dirty;
                lk_data  = lk_data  | ents[i].data;
            end
            if (oldest_dirty[i]) begin
                wb_addr = wb_addr | ents[i].addr;
                wb_data = wb_data | ents[i].data;
            end
        end
    end
endmodule

// File: rtl/vcb_checker.sv
`timescale 1ns/1ps
module vcb_checker
    import vcb_pkg::*;
#(
    parameter int N = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ins_valid,
    input logic             ins_ready,
    input line_addr_t       ins_addr,
    input logic             lk_valid,
    input line_addr_t       lk_addr,
    input logic             lk_hit,
    input logic             wb_valid,
    input logic             wb_ready,
    input line_addr_t       wb_addr,
    input logic [N-1:0]     hit_vec
);
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ins_ready && !wb_valid && !lk_hit));

    a_r2_hit_needs_request: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_valid);

    a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    a_r3_hit_removes: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && !(ins_valid && ins_ready && ins_addr == lk_addr))
        |=> !(lk_hit && lk_addr == $past(lk_addr)));

    a_r6_stall_has_drain: assert property (@(posedge clk) disable iff (rst)
        !ins_ready |-> wb_valid);

    a_r8_accept_moves_on: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_ready && !(ins_valid && ins_ready && ins_addr == wb_addr))
        |=> !(wb_valid && wb_addr == $past(wb_addr)));

    a_r9_offer_holds: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ready && !(lk_hit && lk_addr == wb_addr))
        |=> (wb_valid && wb_addr == $past(wb_addr)));
endmodule

bind victim_wb_buffer vcb_checker #(.N(ENTRIES)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .ins_ready (ins_ready),
    .ins_addr  (ins_addr),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .lk_hit    (lk_hit),
    .wb_valid  (wb_valid),
    .wb_ready  (wb_ready),
    .wb_addr   (wb_addr),
    .hit_vec   (hit_vec)
);

// File: tb/test_victim_wb_buffer.sv
`timescale 1ns/1ps
module test_victim_wb_buffer;
    localparam int N  = 4;
    localparam int AW = 58;
    localparam int DW = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ins_valid = 1'b0, ins_dirty = 1'b0, lk_valid = 1'b0, wb_ready = 1'b0;
    logic [AW-1:0] ins_addr = '0, lk_addr = '0;
    logic [DW-1:0] ins_data = '0;
    logic ins_ready, lk_hit, lk_dirty, wb_valid;
    logic [DW-1:0] lk_data, wb_data;
    logic [AW-1:0] wb_addr;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [AW-1:0] a;
        logic          d;
        logic [DW-1:0] x;
    } ment_t;
    ment_t q[$];

    always #5 clk = ~clk;

    victim_wb_buffer #(.ENTRIES(N)) i_victim_wb_buffer (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_addr(ins_addr),
        .ins_dirty(ins_dirty), .ins_data(ins_data),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
        .lk_dirty(lk_dirty), .lk_data(lk_data),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    function automatic logic [DW-1:0] mkdata(input logic [AW-1:0] a);
        logic [DW-1:0] r;
        for (int k = 0; k < 8; k++) r[k*64 +: 64] = {6'h0, a} ^ (64'h9E37_79B9_0000_0001 * (k + 1));
        return r;
    endfunction

    function automatic bit in_model(input logic [AW-1:0] a);
        for (int i = 0; i < q.size(); i++) if (q[i].a == a) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input bit iv, input logic [AW-1:0] ia, input bit id,
                         input bit lv, input logic [AW-1:0] la, input bit wr);
        ins_valid = iv; ins_addr = ia; ins_dirty = id; ins_data = mkdata(ia);
        lk_valid = lv; lk_addr = la; wb_ready = wr;
    endtask

    task automatic idle();
        drive(0, '0, 0, 0, '0, 0);
    endtask

    // one clock: compare outputs against the model, then advance the model
    task automatic step(input string tag);
        int li, di, vi;
        bit exp_rdy, acc_wb, acc_ins, full, hit;
        logic [AW-1:0] wba, vaddr, lka;
        ment_t ne;
        #1;
        li = -1; di = -1; vi = -1;
        for (int i = 0; i < q.size(); i++) begin
            if (!q[i].d && vi < 0) vi = i;
            if (q[i].d && di < 0) di = i;
            if (lk_valid && q[i].a == lk_addr) li = i;
        end
        full    = (q.size() >= N);
        exp_rdy = !full || (vi >= 0);
        chk(tag, "ins_ready", ins_ready, exp_rdy);
        chk(tag, "wb_valid", wb_valid, di >= 0);
        if (di >= 0) begin
            chk(tag, "wb_addr", wb_addr, q[di].a);
            chk(tag, "wb_data", wb_data, q[di].x);
        end
        chk(tag, "lk_hit", lk_hit, li >= 0);
        if (li >= 0) begin
            chk(tag, "lk_dirty", lk_dirty, q[li].d);
            chk(tag, "lk_data", lk_data, q[li].x);
        end
        acc_wb  = (di >= 0) && wb_ready;
        wba     = (di >= 0) ? q[di].a : '0;
        acc_ins = ins_valid && exp_rdy;
        vaddr   = (full && vi >= 0) ? q[vi].a : '0;
        hit     = li >= 0;
        lka     = lk_addr;
        ne.a = ins_addr; ne.d = ins_dirty; ne.x = ins_data;
        @(posedge clk);
        if (hit) begin
            for (int i = 0; i < q.size(); i++) if (q[i].a == lka) begin q.delete(i); break; end
        end
        if (acc_wb) begin
            for (int i = 0; i < q.size(); i++) if (q[i].a == wba) q[i].d = 1'b0;
        end
        if (acc_ins) begin
            if (full) begin
                for (int i = 0; i < q.size(); i++) if (q[i].a == vaddr) begin q.delete(i); break; end
            end
            q.push_back(ne);
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog run did not finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: empty after reset, lookup misses
        idle(); step("R1");
        drive(0, '0, 0, 1, 58'h42, 0); step("R1");

        // R4: fill free entries with clean lines, read each back
        for (int i = 0; i < N; i++) begin drive(1, 58'h10 + i, 0, 0, '0, 0); step("R4"); end
        for (int i = 0; i < N; i++) begin drive(0, '0, 0, 1, 58'h10 + i, 0); step("R4"); end
        // R3: second lookup of a removed line misses
        drive(0, '0, 0, 1, 58'h11, 0); step("R3");

        // R5: full of clean lines, fifth insert drops the earliest
        for (int i = 0; i < N; i++) begin drive(1, 58'h20 + i, 0, 0, '0, 0); step("R5"); end
        drive(1, 58'h30, 0, 0, '0, 0); step("R5");
        drive(0, '0, 0, 1, 58'h20, 0); step("R5");
        drive(0, '0, 0, 1, 58'h21, 0); step("R5");
        drive(0, '0, 0, 1, 58'h30, 0); step("R5");
        drive(0, '0, 0, 1, 58'h22, 0); step("R5");
        drive(0, '0, 0, 1, 58'h23, 0); step("R5");

        // R6/R7/R9: fill with dirty lines while the next level is busy
        for (int i = 0; i < N; i++) begin drive(1, 58'h40 + i, 1, 0, '0, 0); step("R7"); end
        drive(1, 58'h50, 0, 0, '0, 0); step("R6");
        drive(1, 58'h50, 0, 0, '0, 0); step("R9");
        drive(0, '0, 0, 1, 58'h50, 0); step("R6");
        // R8: accept one, next oldest is offered, cleaned line reads back clean
        drive(0, '0, 0, 0, '0, 1); step("R8");
        idle(); step("R8");
        drive(0, '0, 0, 1, 58'h40, 0); step("R8");
        // R10: lookup of the line drained in the same cycle
        drive(0, '0, 0, 1, 58'h41, 1); step("R10");
        drive(0, '0, 0, 1, 58'h41, 0); step("R10");
        // R10: drain the rest, then lookup hits the victim the insert replaces
        drive(0, '0, 0, 0, '0, 1); step("R10");
        drive(0, '0, 0, 0, '0, 1); step("R10");
        for (int i = 0; i < 2; i++) begin drive(1, 58'h60 + i, 0, 0, '0, 0); step("R10"); end
        drive(1, 58'h70, 1, 1, 58'h42, 0); step("R10");
        drive(0, '0, 0, 1, 58'h42, 0); step("R10");
        drive(0, '0, 0, 1, 58'h70, 0); step("R10");

        // mixed traffic over a small address pool
        for (int c = 0; c < 4000; c++) begin
            logic [AW-1:0] ia, la;
            bit iv;
            ia = 58'h100 + ($urandom % 10);
            la = 58'h100 + ($urandom % 10);
            iv = (($urandom % 3) == 0) && !in_model(ia);
            drive(iv, ia, $urandom % 2, $urandom % 2, la, ($urandom % 3) != 0);
            step("R2");
        end
        idle();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule